// File: doc/BRIEF.md
# Supply Monitor Status and Control Register

This block is one byte-wide, memory-mapped register that sits between a supply-voltage comparator and the rest of the chip. A raw low-supply indication from the comparator passes through a synchronizer. It then latches a sticky status flag. Software clears the flag by writing a one to a dedicated acknowledge position. The flag can drive an interrupt request, a system reset request, or both, depending on the enables held in the same byte.

The monitor enable and the reset enable can each be written only once after reset. Boot code uses this to fix the supply-protection policy so that later software cannot change it. A separate stop-mode enable decides whether the monitor keeps running while the chip is in stop mode. The byte also carries an enable for the bandgap reference buffer. Reads are combinational from the register state.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: After reset, every read bit is 0, and irq, rst_req, mon_en and bg_buf_en are all 0.
- R2: A raw event is synchronized through two flops. When lv_raw rises while mon_en is 1, the flag (read bit 7) reads 1 after the third rising clock edge.
- R3: A write with data bit 6 set clears the flag on that edge. Read bit 6 always returns 0.
- R4: If a synchronized event and an acknowledge write land on the same edge, the flag stays 1.
- R5: irq is 1 exactly when the flag is 1 and the interrupt enable (bit 5) is 1.
- R6: rst_req is 1 exactly when the flag, the reset enable (bit 4) and the detect enable (bit 2) are all 1.
- R7: The detect enable (bit 2) and the reset enable (bit 4) are loaded by the first write after reset only. Later writes leave them unchanged but still update bits 5, 3 and 0.
- R8: mon_en equals detect enable AND (NOT stop_mode OR stop enable, bit 3). While mon_en is 0, raw events never set the flag.
- R9: Bit 1 is reserved and always reads 0. Bit 0 is read/write and drives bg_buf_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register readback |
| lv_raw | input | 1 | Asynchronous low-supply indication from comparator |
| stop_mode | input | 1 | Chip is in stop mode |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | System reset request |
| mon_en | output | 1 | Enable for the analog comparator |
| bg_buf_en | output | 1 | Bandgap reference buffer enable |

## Verification
Several rules are checked by the assertions on every cycle. The locked policy bits must stay stable. The flag must not rise while the monitor is gated off. An acknowledge with no coincident event must clear the flag. irq and rst_req must be implied by their enables. Other behaviour only the bench scenarios can show: the exact three-edge latency from the raw input, the first-write-wins locking across a reset, and stop-mode gating with the stop enable both set and clear. These scenarios are compared each cycle against a behavioural model.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int REG_W  = 8;
  localparam int B_FLAG = 7;
  localparam int B_ACK  = 6;
  localparam int B_IE   = 5;
  localparam int B_RE   = 4;
  localparam int B_SE   = 3;
  localparam int B_DE   = 2;
  localparam int B_RSV  = 1;
  localparam int B_BG   = 0;

  typedef struct packed {
    logic ie;
    logic re;
    logic se;
    logic de;
    logic bg;
  } lvd_ctl_t;

  function automatic logic mon_gate(input logic de, input logic se, input logic stop);
    return de & (~stop | se);
  endfunction

  function automatic logic [REG_W-1:0] pack_rd(input logic flag, input lvd_ctl_t c);
    logic [REG_W-1:0] r;
    r         = '0;
    r[B_FLAG] = flag;
    r[B_IE]   = c.ie;
    r[B_RE]   = c.re;
    r[B_SE]   = c.se;
    r[B_DE]   = c.de;
    r[B_BG]   = c.bg;
    return r;
  endfunction
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[0] <= 1'b0;
          else        pipe[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) pipe[g] <= 1'b0;
          else        pipe[g] <= pipe[g-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/lvd_ctl.sv
module lvd_ctl
  import lvd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output lvd_ctl_t         ctl,
  output logic             locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      locked <= 1'b0;
    end else if (wr_en) begin
      ctl.ie <= wr_data[B_IE];
      ctl.se <= wr_data[B_SE];
      ctl.bg <= wr_data[B_BG];
      if (!locked) begin
        ctl.de <= wr_data[B_DE];
        ctl.re <= wr_data[B_RE];
        locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lvd_flag.sv
module lvd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic ack_evt,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (ack_evt) flag <= 1'b0;
endmodule

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg
  import lvd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             lv_raw,
  input  logic             stop_mode,
  output logic             irq,
  output logic             rst_req,
  output logic             mon_en,
  output logic             bg_buf_en
);
  lvd_ctl_t ctl;
  logic     locked;
  logic     sync_lv;
  logic     set_evt;
  logic     ack_evt;
  logic     flag;

  lvd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(lv_raw), .q(sync_lv)
  );

  lvd_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctl(ctl), .locked(locked)
  );

  assign mon_en  = mon_gate(ctl.de, ctl.se, stop_mode);
  assign set_evt = sync_lv & mon_en;
  assign ack_evt = wr_en & wr_data[B_ACK];

  lvd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .ack_evt(ack_evt), .flag(flag)
  );

  assign rd_data   = pack_rd(flag, ctl);
  assign irq       = flag & ctl.ie;
  assign rst_req   = flag & ctl.re & ctl.de;
  assign bg_buf_en = ctl.bg;
endmodule

// File: rtl/lvd_ctrl_reg_chk.sv
module lvd_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       rst_req,
  input logic       mon_en,
  input logic       set_evt,
  input logic       locked
);
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[6] && !set_evt) |=> !rd_data[7]);

  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> rd_data[7]);

  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rd_data[7] && rd_data[5]));

  a_r6_reset_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rd_data[7] && rd_data[4] && rd_data[2]));

  a_r7_detect_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(rd_data[2]) && $stable(rd_data[4]));

  a_r8_gated_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_en && !rd_data[7]) |=> !rd_data[7]);
endmodule

bind lvd_ctrl_reg lvd_ctrl_reg_chk u_chk (.*);

// File: tb/sim_lvd_ctrl_reg.sv
module sim_lvd_ctrl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       lv_raw = 1'b0;
  logic       stop_mode = 1'b0;
  logic [7:0] rd_data;
  logic       irq, rst_req, mon_en, bg_buf_en;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  lvd_ctrl_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .lv_raw(lv_raw), .stop_mode(stop_mode), .irq(irq), .rst_req(rst_req),
    .mon_en(mon_en), .bg_buf_en(bg_buf_en)
  );

  // behavioural reference model
  bit m_flag, m_ie, m_re, m_se, m_de, m_bg, m_lock;
  bit pipe[$] = '{0, 0};

  function automatic bit m_mon();
    return m_de && (!stop_mode || m_se);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_flag, m_ie, m_re, m_se, m_de, m_bg, m_lock} = '0;
      pipe = '{0, 0};
    end else begin
      bit oldest, setv, ackv;
      oldest = pipe.pop_front();
      pipe.push_back(lv_raw);
      setv = oldest && m_mon();
      ackv = wr_en && wr_data[6];
      if (setv) m_flag = 1;
      else if (ackv) m_flag = 0;
      if (wr_en) begin
        m_ie = wr_data[5]; m_se = wr_data[3]; m_bg = wr_data[0];
        if (!m_lock) begin m_de = wr_data[2]; m_re = wr_data[4]; m_lock = 1; end
      end
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2/R3 flag", rd_data[7], m_flag);
      check("R7 ctrl bits", {rd_data[5], rd_data[4], rd_data[3], rd_data[2]},
            {m_ie, m_re, m_se, m_de});
      check("R9 reserved/ack read", {rd_data[6], rd_data[1]}, 0);
      check("R9 bg", {rd_data[0], bg_buf_en}, {m_bg, m_bg});
      check("R5 irq", irq, m_flag && m_ie);
      check("R6 rst_req", rst_req, m_flag && m_re && m_de);
      check("R8 mon_en", mon_en, m_mon());
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); #2; wr_en = 1'b1; wr_data = d;
    @(negedge clk); #2; wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic do_reset();
    @(negedge clk); #2; rst_n = 1'b0;
    cyc(2); #2; rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(2); #2; rst_n = 1'b1;
    cyc(1);
    check("R1 reset rd", rd_data, 8'h00);
    check("R1 reset outs", {irq, rst_req, mon_en, bg_buf_en}, 0);

    wr(8'h25);                       // ie, de, bg
    check("R9 bg after write", bg_buf_en, 1);
    // R2: latency of three edges
    @(negedge clk); #2; lv_raw = 1'b1;
    @(negedge clk); check("R2 edge1", rd_data[7], 0);
    @(negedge clk); check("R2 edge2", rd_data[7], 0);
    @(negedge clk); check("R2 edge3", rd_data[7], 1);
    check("R5 irq raised", irq, 1);

    // R7: second write cannot change de/re
    wr(8'h14);
    check("R7 locked", rd_data, 8'h84);
    check("R5 irq off", irq, 0);

    // R4: ack while event still present
    wr(8'h65);
    check("R4 event wins", rd_data[7], 1);
    @(negedge clk); #2; lv_raw = 1'b0;
    cyc(3);
    wr(8'h65);
    check("R3 ack clears", rd_data[7], 0);
    check("R3 ack reads 0", rd_data[6], 0);

    // R8: stop without stop enable
    wr(8'h25);
    @(negedge clk); #2; stop_mode = 1'b1;
    @(negedge clk); check("R8 gated", mon_en, 0);
    #2; lv_raw = 1'b1;
    cyc(5);
    check("R8 ignored", rd_data[7], 0);
    #2; lv_raw = 1'b0;
    cyc(3); #2; stop_mode = 1'b0;
    cyc(2);
    check("R8 still clear", rd_data[7], 0);

    // R6 with new policy after reset; R9 reserved bit
    do_reset();
    cyc(1);
    check("R1 after reset", rd_data, 8'h00);
    wr(8'h1E);
    check("R9 reserved", rd_data, 8'h1C);
    @(negedge clk); #2; stop_mode = 1'b1;
    @(negedge clk); check("R8 stop enabled", mon_en, 1);
    #2; lv_raw = 1'b1;
    cyc(3);
    check("R6 rst_req", rst_req, 1);
    check("R5 no irq", irq, 0);
    #2; lv_raw = 1'b0; stop_mode = 1'b0;
    cyc(3);
    wr(8'h48);
    check("R3 clear rst_req", rst_req, 0);
    check("R7 re kept", rd_data[4], 1);
    cyc(2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule